// File: doc/BRIEF.md
# Ring-Cascaded Three-Channel Timer Group

A group of three 16-bit timer channels that share one clock prescaler and one byte-wide register bus. Each channel holds a mode register, a reload register and a counter. It runs as a down-counting timer on a divided clock, or as a down-counting event counter. The event counter is fed either by edges of its own external pin or by the underflow pulse of the previous channel in a ring: channel 0 listens to channel 2. A channel can also count up from a divided clock and capture the period or the pulse width of its pin. Every channel drives a one-cycle pulse, `uf_pulse`, on underflow or on each measurement capture. An interrupt controller would normally take this pulse.

Software sets the reload value and the mode while a channel is stopped, then sets the channel's bit in the start register. The register bus is a plain single-cycle port. A write lands on the next rising clock edge, and read data is combinational from the address. The bus has no handshake and no back-pressure: every access completes in the cycle it is presented. The slow sub-clock arrives as a one-cycle enable, `sub_tick`, that comes from outside the block.

Top module: `tmr_group`

## Requirements
- R1: After reset, every mode register, reload register, counter and the start register read 0, and all `uf_pulse` bits are 0.
- R2: Channel n occupies bus addresses 8n to 8n+4:
  - +0 and +1 read the counter's low and high byte.
  - +2 and +3 read the reload register's low and high byte.
  - +4 is the mode register.
  - A write to +0 or +1 acts exactly like a write to +2 or +3.
  - Address 24 is the start register, with bit n enabling channel n.
  - Any other address reads 0.
  - Mode bit 3 of channel 0 is read-only and always reads 0.
- R3: A byte write to the reload register of a stopped channel also loads the same byte of its counter. On a running channel it changes only the reload register.
- R4: With mode bits [1:0]=00 (timer), a running channel decrements once per tick of the clock chosen by bits [7:6]: 00 every clock, 01 every 8th clock, 10 every 32nd clock, 11 every 32nd `sub_tick`.
- R5: In timer or event mode, a count step taken when the counter is 0 reloads it from the reload register and raises `uf_pulse` for exactly that one following cycle.
- R6: A channel whose start bit is 0 never changes its counter except through bus writes. Writing the start register takes effect one cycle later.
- R7: With mode [1:0]=01 and bit 4=0, the channel counts its pin: rising edges when bit 2=0, falling edges when bit 2=1. The pin goes through a two-flop synchroniser first, and each edge counts once.
- R8: With mode [1:0]=01 and bit 4=1, channel n counts each underflow pulse of channel n-1, and channel 0 counts those of channel 2.
- R9: With mode [1:0]=10 and bit 3=0, the counter increments on each selected clock tick. At each pin edge chosen by bit 2, it copies its value into the reload register, clears to 0 and pulses `uf_pulse`.
- R10: With mode [1:0]=10 and bit 3=1, capture happens on both pin edges, so the reload register alternately holds the high and the low width.
- R11: Mode [1:0]=11 is reserved: the counter holds and no pulse is produced, even when started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle enable of the slow sub-clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_in | input | 3 | External pin of each channel |
| uf_pulse | output | 3 | Per-channel underflow / capture pulse |

## Verification
The timer path is exercised at every clock-select setting: a reload of 2 on the undivided clock, and a reload of 0 on the /8, /32 and sub-clock settings. Counting the pulses in a fixed window tells the four divide ratios apart. The event path is driven with clean pin pulses, first with rising and then with falling polarity. The difference in the final count shows which edge was taken and that each edge counted once. The cascade is driven by a channel 2 underflowing every clock, so that channel 0 and then channel 1 move only through the ring. Measurement uses a 4-high/6-low waveform: period mode must capture 9 while width mode captures 3 and 5. A behavioural model compares pulses and read data on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_EVENT = 2'b01,
    MD_MEAS  = 2'b10,
    MD_RSVD  = 2'b11
  } tmr_mode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int FAST_LOG = 3,
  parameter int SLOW_LOG = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  output logic [3:0] ticks
);
  logic [SLOW_LOG-1:0] main_q;
  logic [SLOW_LOG-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= '0;
      sub_q  <= '0;
    end else begin
      main_q <= main_q + 1'b1;
      if (sub_tick) sub_q <= sub_q + 1'b1;
    end
  end

  // Index matches the 2-bit clock select field.
  assign ticks[0] = 1'b1;
  assign ticks[1] = &main_q[FAST_LOG-1:0];
  assign ticks[2] = &main_q;
  assign ticks[3] = sub_tick & (&sub_q);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
  assign fall = ~sync_q & last_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  tmr_mode_e       mode,
  input  logic            edge_fall,
  input  logic            width_sel,
  input  logic            casc_sel,
  input  logic [1:0]      clk_sel,
  input  logic [3:0]      ticks,
  input  logic            rise,
  input  logic            fall,
  input  logic            casc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [7:0]      wdata,
  output logic [CW-1:0]   cnt,
  output logic [CW-1:0]   rld,
  output logic            uf
);
  logic tick, pin_ev, down_en, meas_edge;

  assign tick      = ticks[clk_sel];
  assign pin_ev    = edge_fall ? fall : rise;
  assign down_en   = (mode == MD_TIMER) ? tick :
                     (mode == MD_EVENT) ? (casc_sel ? casc : pin_ev) : 1'b0;
  assign meas_edge = (mode == MD_MEAS) && (width_sel ? (rise | fall) : pin_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
      uf  <= 1'b0;
    end else begin
      uf <= 1'b0;
      if (wr_lo) begin
        rld[7:0] <= wdata;
        if (!run) cnt[7:0] <= wdata;
      end
      if (wr_hi) begin
        rld[CW-1:8] <= wdata[CW-9:0];
        if (!run) cnt[CW-1:8] <= wdata[CW-9:0];
      end
      if (run) begin
        if (meas_edge) begin
          rld <= cnt;
          cnt <= '0;
          uf  <= 1'b1;
        end else if (mode == MD_MEAS && tick) begin
          cnt <= cnt + 1'b1;
        end else if (down_en) begin
          if (cnt == '0) begin
            cnt <= rld;
            uf  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && down_en && cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1))); // R4
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && down_en && cnt == '0) |=> (uf && cnt == $past(rld))); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt)); // R6
  AST_MEAS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && meas_edge) |=> (uf && cnt == '0 && rld == $past(cnt))); // R9
  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RSVD && !wr_lo && !wr_hi) |=> ($stable(cnt) && !uf)); // R11
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int CW       = 16,
  parameter int ADW      = 5,
  parameter int FAST_LOG = 3,
  parameter int SLOW_LOG = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sub_tick,
  input  logic           bus_wr,
  input  logic [ADW-1:0] bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [NCH-1:0] ext_in,
  output logic [NCH-1:0] uf_pulse
);
  localparam int STRIDE_LOG = 3;
  localparam logic [ADW-1:0] START_A = ADW'(NCH << STRIDE_LOG);

  logic [3:0]     ticks;
  logic [NCH-1:0] start_q;
  logic [7:0]     mr_q  [NCH];
  logic [CW-1:0]  cnt_a [NCH];
  logic [CW-1:0]  rld_a [NCH];
  logic [NCH-1:0] uf_a;

  tmr_prescale #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .ticks(ticks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (bus_wr && bus_addr == START_A) start_q <= bus_wdata[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [7:0] MR_MASK = (g == 0) ? 8'hF7 : 8'hFF;
    logic hit, wr_lo, wr_hi, rise, fall;

    assign hit   = bus_wr && (bus_addr[ADW-1:STRIDE_LOG] == (ADW-STRIDE_LOG)'(g));
    assign wr_lo = hit && (bus_addr[2:0] == 3'd0 || bus_addr[2:0] == 3'd2);
    assign wr_hi = hit && (bus_addr[2:0] == 3'd1 || bus_addr[2:0] == 3'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) mr_q[g] <= '0;
      else if (hit && bus_addr[2:0] == 3'd4) mr_q[g] <= bus_wdata & MR_MASK;
    end

    tmr_edge u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_in[g]), .rise(rise), .fall(fall)
    );

    tmr_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(start_q[g]),
      .mode(tmr_mode_e'(mr_q[g][1:0])),
      .edge_fall(mr_q[g][2]), .width_sel(mr_q[g][3]), .casc_sel(mr_q[g][4]),
      .clk_sel(mr_q[g][7:6]), .ticks(ticks), .rise(rise), .fall(fall),
      .casc(uf_a[(g + NCH - 1) % NCH]),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
      .cnt(cnt_a[g]), .rld(rld_a[g]), .uf(uf_a[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr[ADW-1:STRIDE_LOG] == (ADW-STRIDE_LOG)'(i)) begin
        case (bus_addr[2:0])
          3'd0:    bus_rdata = cnt_a[i][7:0];
          3'd1:    bus_rdata = 8'(cnt_a[i][CW-1:8]);
          3'd2:    bus_rdata = rld_a[i][7:0];
          3'd3:    bus_rdata = 8'(rld_a[i][CW-1:8]);
          3'd4:    bus_rdata = mr_q[i];
          default: bus_rdata = '0;
        endcase
      end
    end
    if (bus_addr == START_A) bus_rdata = 8'(start_q);
  end

  assign uf_pulse = uf_a;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == START_A) |=> (start_q == $past(bus_wdata[NCH-1:0]))); // R6
endmodule

// File: tb/sim_tmr_group.sv
`timescale 1ns/1ps
module sim_tmr_group;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [N-1:0] ext_in = '0;
  logic [N-1:0] uf_pulse;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_cnt[N], m_rld[N], m_mr[N], m_uf[N], s1[N], s2[N], s3[N];
  int m_start, m_pc, m_sc;

  tmr_group u0 (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .uf_pulse(uf_pulse)
  );

  always #2.5 clk = ~clk;

  function automatic int mread(input int a);
    int c, k;
    if (a == 24) return m_start;
    if (a >= 24) return 0;
    c = a / 8; k = a % 8;
    case (k)
      0: return m_cnt[c] & 255;
      1: return m_cnt[c] >> 8;
      2: return m_rld[c] & 255;
      3: return m_rld[c] >> 8;
      4: return m_mr[c];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_mr[c] = 0; m_uf[c] = 0;
        s1[c] = 0; s2[c] = 0; s3[c] = 0;
      end
      m_start = 0; m_pc = 0; m_sc = 0;
    end else begin
      int t[4];
      int old_uf[N], ncnt[N], nrld[N], nuf[N];
      t[0] = 1;
      t[1] = (m_pc % 8 == 7);
      t[2] = (m_pc == 31);
      t[3] = (sub_tick && m_sc == 31);
      for (int c = 0; c < N; c++) begin
        old_uf[c] = m_uf[c]; ncnt[c] = m_cnt[c]; nrld[c] = m_rld[c];
      end
      if (bus_wr && bus_addr < 24 && (bus_addr % 8) < 4) begin
        int c, hi;
        c = bus_addr / 8; hi = bus_addr % 2;
        if (hi) begin
          nrld[c] = (nrld[c] & 255) | (bus_wdata << 8);
          if (!m_start[c]) ncnt[c] = (ncnt[c] & 255) | (bus_wdata << 8);
        end else begin
          nrld[c] = (nrld[c] & 16'hFF00) | bus_wdata;
          if (!m_start[c]) ncnt[c] = (ncnt[c] & 16'hFF00) | bus_wdata;
        end
      end
      for (int c = 0; c < N; c++) begin
        int md, tk, rise, fall, pev, den, medge;
        md = m_mr[c] & 3;
        tk = t[m_mr[c] >> 6];
        rise = s2[c] && !s3[c];
        fall = !s2[c] && s3[c];
        pev = (m_mr[c] & 4) ? fall : rise;
        den = (md == 0) ? tk : (md == 1) ? ((m_mr[c] & 16) ? old_uf[(c + N - 1) % N] : pev) : 0;
        medge = (md == 2) && ((m_mr[c] & 8) ? (rise || fall) : pev);
        nuf[c] = 0;
        if (m_start[c]) begin
          if (medge) begin
            nrld[c] = m_cnt[c]; ncnt[c] = 0; nuf[c] = 1;
          end else if (md == 2 && tk) begin
            ncnt[c] = (m_cnt[c] + 1) & 16'hFFFF;
          end else if (den) begin
            if (m_cnt[c] == 0) begin ncnt[c] = m_rld[c]; nuf[c] = 1; end
            else ncnt[c] = m_cnt[c] - 1;
          end
        end
      end
      for (int c = 0; c < N; c++) begin
        m_cnt[c] = ncnt[c]; m_rld[c] = nrld[c]; m_uf[c] = nuf[c];
        s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = ext_in[c];
      end
      if (bus_wr && bus_addr < 24 && (bus_addr % 8) == 4)
        m_mr[bus_addr / 8] = (bus_addr / 8 == 0) ? (bus_wdata & 8'hF7) : bus_wdata;
      if (bus_wr && bus_addr == 24) m_start = bus_wdata & 7;
      m_pc = (m_pc + 1) % 32;
      if (sub_tick) m_sc = (m_sc + 1) % 32;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_uf;
      exp_uf = m_uf[0] | (m_uf[1] << 1) | (m_uf[2] << 2);
      check(cur_req, "uf_pulse", int'(uf_pulse), exp_uf);
      check(cur_req, "rdata", int'(bus_rdata), mread(int'(bus_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); #1;
    bus_addr = 5'(a);
    #0.5;
    v = int'(bus_rdata);
  endtask

  task automatic chk_rd(input int a, input int exp, input string req);
    int v;
    rd(a, v);
    check(req, $sformatf("read @%0d", a), v, exp);
  endtask

  task automatic count_uf(input int ch, input int n, output int k);
    k = 0;
    repeat (n) begin
      @(negedge clk);
      if (uf_pulse[ch]) k++;
    end
    #1;
  endtask

  task automatic pin_pulse(input int ch, input int hi, input int lo);
    @(negedge clk); #1; ext_in[ch] = 1'b1;
    repeat (hi) @(negedge clk);
    #1; ext_in[ch] = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, v2, k;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    check("R1", "uf after reset", int'(uf_pulse), 0);
    for (int a = 0; a <= 24; a++) chk_rd(a, 0, "R1");

    // R2 / R3: map and stopped load
    cur_req = "R3";
    wr(10, 8'h34); wr(11, 8'h12);
    chk_rd(8, 8'h34, "R3"); chk_rd(9, 8'h12, "R3");
    chk_rd(10, 8'h34, "R2"); chk_rd(11, 8'h12, "R2");
    cur_req = "R2";
    wr(0, 8'h77);                         // counter address acts as reload write
    chk_rd(2, 8'h77, "R2");
    wr(4, 8'hFF); chk_rd(4, 8'hF7, "R2");
    wr(12, 8'hFF); chk_rd(12, 8'hFF, "R2");
    wr(4, 8'h0A); chk_rd(4, 8'h02, "R2");
    wr(4, 0); wr(12, 0);
    chk_rd(30, 0, "R2");

    // R4 / R5: timer mode, undivided clock, reload 2
    cur_req = "R5";
    wr(2, 2); wr(3, 0);
    wr(24, 1);
    count_uf(0, 30, k); check("R5", "uf per 30 cycles, reload 2", k, 10);
    cur_req = "R3";
    wr(2, 5); chk_rd(2, 5, "R3");
    idle(12);

    // R6: freeze
    cur_req = "R6";
    wr(24, 0);
    rd(0, v); idle(6); rd(0, v2);
    check("R6", "counter frozen", v2, v);
    chk_rd(24, 0, "R6");

    // R4: clock selects with reload 0
    cur_req = "R4";
    wr(2, 0); wr(3, 0);
    wr(4, 8'h40); wr(24, 1);
    count_uf(0, 80, k); check("R4", "uf per 80 cycles, /8", k, 10);
    wr(24, 0); wr(4, 8'h80); wr(24, 1);
    count_uf(0, 64, k); check("R4", "uf per 64 cycles, /32", k, 2);
    wr(24, 0); wr(4, 8'hC0);
    sub_tick = 1'b1;
    wr(24, 1);
    count_uf(0, 64, k); check("R4", "uf per 64 sub ticks", k, 2);
    sub_tick = 1'b0;
    count_uf(0, 64, k); check("R4", "no uf without sub ticks", k, 0);
    wr(24, 0); wr(4, 0);

    // R7: event counting on pin of channel 2
    cur_req = "R7";
    wr(18, 100); wr(19, 0); wr(20, 8'h01); wr(24, 4);
    for (int i = 0; i < 5; i++) pin_pulse(2, 3, 3);
    idle(5);
    chk_rd(16, 95, "R7");
    wr(20, 8'h05);
    for (int i = 0; i < 3; i++) pin_pulse(2, 3, 3);
    idle(5);
    chk_rd(16, 92, "R7");
    wr(24, 0);

    // R8: ring cascade 2 -> 0 -> 1
    cur_req = "R8";
    wr(2, 1); wr(3, 0); wr(4, 8'h11);
    wr(10, 50); wr(11, 0); wr(12, 8'h11);
    wr(18, 0); wr(19, 0); wr(20, 8'h00);
    wr(24, 7);
    idle(20);
    wr(24, 0);
    rd(8, v);
    check("R8", "channel 1 moved through ring", int'(v != 50 && v > 30), 1);
    rd(0, v);
    check("R8", "channel 0 within reload", int'(v <= 1), 1);

    // R9: period measurement on channel 1
    cur_req = "R9";
    wr(12, 8'h02); wr(24, 2);
    for (int i = 0; i < 5; i++) pin_pulse(1, 4, 6);
    idle(4);
    chk_rd(10, 9, "R9");
    chk_rd(11, 0, "R9");

    // R10: width measurement
    cur_req = "R10";
    wr(12, 8'h0A);
    k = 0;
    for (int i = 0; i < 4; i++) pin_pulse(1, 4, 6);
    idle(4);
    chk_rd(10, 3, "R10");
    wr(24, 0);

    // R11: reserved mode holds
    cur_req = "R11";
    wr(18, 8'h21); wr(20, 8'h03); wr(24, 4);
    rd(16, v);
    pin_pulse(2, 2, 2);
    count_uf(2, 20, k); check("R11", "no pulse in reserved mode", k, 0);
    rd(16, v2); check("R11", "counter held", v2, v);
    wr(24, 0);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule